// File: doc/BRIEF.md
# Time-Slot Payload Substitution Unit

This block sits in the transmit serial path of a T1/E1 framer and rewrites the payload of individual 8-bit time slots while the bit stream flows through it. A bit strobe marks each serial bit on the system clock. A frame-sync pulse, given together with the strobe, marks the first bit of a frame. A mode input selects T1 (one framing bit plus 24 slots) or E1 (32 slots and no framing bit). For every bit the block looks up the substitution mode of the current slot and drives the resulting bit on its output, one clock after the strobe.

Each slot has a 4-bit mode in a table that software fills through a simple write port. Writes land in a shadow copy, which becomes active at the next frame sync, so a frame never mixes old and new settings. The available modes are these: pass-through, several bit-inversion patterns, fixed idle codes, a shared user code, a built-in PRBS and an external fractional-data feed.

Top module: `tslot_subst`

## Requirements
- R1: While rstN is low, serOut is 0, every active and shadow table entry is mode 0, and the PRBS register holds all ones. After reset, and before any write, all slots pass data unchanged.
- R2: The output bit for a strobe with bitEn high appears on serOut one clock after that strobe. serOut keeps its value on every cycle in which bitEn is low.
- R3: A strobe with frameSync high is the first bit of a frame. In T1 that bit is the framing bit, followed by slots 0..23 of 8 bits each. In E1 it is bit 1 of slot 0, and slots 0..31 follow. Without a sync the count wraps by itself at the frame end.
- R4: The T1 framing bit is always copied from serIn unchanged.
- R5: Bits in a slot are numbered 1..8, with bit 1 the MSB and sent first. Mode 1 inverts all bits. Mode 2 inverts bits 2,4,6,8. Mode 3 inverts bits 1,3,5,7. Mode 8 inverts bit 1 only. Mode 9 inverts bits 2..8.
- R6: Mode 4 sends the 8-bit userCode, mode 5 sends 0xFF, mode 6 sends 0xD5 and mode 7 sends 0x00, each MSB first, with serIn ignored.
- R7: Mode 10 sends bit 15 of a 15-bit PRBS register. That register then shifts left, taking bit15 XOR bit14 (polynomial x^15+x^14+1) into bit 1. It advances only on strobes of bits in mode-10 slots.
- R8: Mode 11 sends the fracIn value sampled on the same strobe.
- R9: Modes 0 and 12..15 pass serIn unchanged.
- R10: cfgWe writes cfgMode into the shadow entry cfgAddr. The active table copies the whole shadow table on the strobe with frameSync high, and that frame's first bit already uses the new table. Writes have no effect before then.
- R11: In E1, slots 0 and 16 take substitution modes in the same way as all other slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle strobe per serial bit |
| frameSync | input | 1 | With bitEn, marks the first bit of a frame |
| modeE1 | input | 1 | 1 = E1 framing, 0 = T1 framing |
| serIn | input | 1 | Incoming PCM bit |
| fracIn | input | 1 | Fractional payload bit |
| cfgWe | input | 1 | Shadow table write enable |
| cfgAddr | input | 5 | Slot number to write |
| cfgMode | input | 4 | Mode value to write |
| userCode | input | 8 | Code sent in mode 4 |
| serOut | output | 1 | Rewritten PCM bit |

## Verification
Every bit result is due exactly one clock after its strobe. The driver pushes the expected bit when it applies the strobe at a falling edge. The monitor pops and compares at the following falling edge, and only if a strobe was registered at the rising edge between them. On falling edges with no pending strobe, the monitor checks that serOut still holds the last expected bit. Table changes are due at the first bit of the next synced frame, so the reference model copies its own shadow table at that same strobe.

// File: rtl/tslot_pkg.sv
package tslot_pkg;
  localparam int SLOT_BITS = 8;
  localparam int IDX_W     = $clog2(SLOT_BITS);
  localparam int MODE_W    = 4;

  localparam logic [MODE_W-1:0] M_PASS     = 4'd0;
  localparam logic [MODE_W-1:0] M_INV_ALL  = 4'd1;
  localparam logic [MODE_W-1:0] M_INV_EVEN = 4'd2;
  localparam logic [MODE_W-1:0] M_INV_ODD  = 4'd3;
  localparam logic [MODE_W-1:0] M_USER     = 4'd4;
  localparam logic [MODE_W-1:0] M_ONES     = 4'd5;
  localparam logic [MODE_W-1:0] M_VACANT   = 4'd6;
  localparam logic [MODE_W-1:0] M_ZEROS    = 4'd7;
  localparam logic [MODE_W-1:0] M_INV_MSB  = 4'd8;
  localparam logic [MODE_W-1:0] M_INV_LOW  = 4'd9;
  localparam logic [MODE_W-1:0] M_PRBS     = 4'd10;
  localparam logic [MODE_W-1:0] M_FRAC     = 4'd11;

  typedef struct packed {
    logic              strobe;
    logic              fbit;
    logic [IDX_W-1:0]  bitIdx;
    logic [MODE_W-1:0] mode;
  } ctrlStrobeT;
endpackage

// File: rtl/tslot_ctrl.sv
module tslot_ctrl
  import tslot_pkg::*;
#(
  parameter int T1_SLOTS = 24,
  parameter int E1_SLOTS = 32,
  localparam int SLOT_W  = $clog2(E1_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              frameSync,
  input  logic              modeE1,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgAddr,
  input  logic [MODE_W-1:0] cfgMode,
  output ctrlStrobeT        ctl
);
  logic [E1_SLOTS-1:0][MODE_W-1:0] shadowTab, activeTab;
  logic              nxtFbit;
  logic [SLOT_W-1:0] nxtSlot;
  logic [IDX_W-1:0]  nxtIdx;

  logic              load, curFbit, advFbit;
  logic [SLOT_W-1:0] curSlot, advSlot, lastSlot;
  logic [IDX_W-1:0]  curIdx, advIdx;
  logic [MODE_W-1:0] tabEntry;

  always_comb begin
    load     = bitEn & frameSync;
    curFbit  = load ? ~modeE1 : (nxtFbit & ~modeE1);
    curSlot  = load ? '0 : nxtSlot;
    curIdx   = load ? '0 : nxtIdx;
    lastSlot = modeE1 ? SLOT_W'(E1_SLOTS - 1) : SLOT_W'(T1_SLOTS - 1);
    advFbit  = 1'b0;
    advSlot  = curSlot;
    advIdx   = curIdx + 1'b1;
    if (curFbit) begin
      advSlot = '0;
      advIdx  = '0;
    end else if (curIdx == IDX_W'(SLOT_BITS - 1)) begin
      advIdx = '0;
      if (curSlot >= lastSlot) begin
        advSlot = '0;
        advFbit = ~modeE1;
      end else begin
        advSlot = curSlot + 1'b1;
      end
    end
    tabEntry = load ? shadowTab[curSlot] : activeTab[curSlot];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nxtFbit <= 1'b0;
      nxtSlot <= '0;
      nxtIdx  <= '0;
    end else if (bitEn) begin
      nxtFbit <= advFbit;
      nxtSlot <= advSlot;
      nxtIdx  <= advIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowTab <= '0;
      activeTab <= '0;
    end else begin
      if (cfgWe) shadowTab[cfgAddr] <= cfgMode;
      if (load) activeTab <= shadowTab;
    end
  end

  always_comb begin
    ctl.strobe = bitEn;
    ctl.fbit   = curFbit;
    ctl.bitIdx = curIdx;
    ctl.mode   = curFbit ? M_PASS : tabEntry;
  end

  a_r3_slot_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !curFbit) |-> (curSlot <= lastSlot));
  a_r10_table_holds: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> $stable(activeTab));
  a_r3_pos_holds: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(nxtIdx) && $stable(nxtSlot)));
endmodule

// File: rtl/tslot_dp.sv
module tslot_dp
  import tslot_pkg::*;
#(
  parameter int PRBS_W = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrobeT ctl,
  input  logic       serIn,
  input  logic       fracIn,
  input  logic [7:0] userCode,
  output logic       serOut
);
  logic [PRBS_W-1:0] lfsr;
  logic              prbsStep, outBit, isMsb;
  logic [IDX_W-1:0]  codeIdx;

  always_comb begin
    isMsb    = (ctl.bitIdx == '0);
    codeIdx  = ~ctl.bitIdx;
    prbsStep = ctl.strobe & ~ctl.fbit & (ctl.mode == M_PRBS);
    case (ctl.mode)
      M_INV_ALL:  outBit = ~serIn;
      M_INV_EVEN: outBit = serIn ^ ctl.bitIdx[0];
      M_INV_ODD:  outBit = serIn ^ ~ctl.bitIdx[0];
      M_USER:     outBit = userCode[codeIdx];
      M_ONES:     outBit = 1'b1;
      M_VACANT:   outBit = 8'hD5 >> codeIdx;
      M_ZEROS:    outBit = 1'b0;
      M_INV_MSB:  outBit = serIn ^ isMsb;
      M_INV_LOW:  outBit = serIn ^ ~isMsb;
      M_PRBS:     outBit = lfsr[PRBS_W-1];
      M_FRAC:     outBit = fracIn;
      default:    outBit = serIn;
    endcase
    if (ctl.fbit) outBit = serIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr   <= '1;
      serOut <= 1'b0;
    end else begin
      if (ctl.strobe) serOut <= outBit;
      if (prbsStep) lfsr <= {lfsr[PRBS_W-2:0], lfsr[PRBS_W-1] ^ lfsr[PRBS_W-2]};
    end
  end

  a_r7_lfsr_alive: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);
  a_r7_lfsr_idle: assert property (@(posedge clk) disable iff (!rstN)
    !prbsStep |=> $stable(lfsr));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.strobe |=> $stable(serOut));
  a_r4_fbit_through: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.strobe && ctl.fbit) |=> (serOut == $past(serIn)));
  a_r6_ones: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.strobe && !ctl.fbit && ctl.mode == M_ONES) |=> serOut);
  a_r8_frac: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.strobe && !ctl.fbit && ctl.mode == M_FRAC) |=> (serOut == $past(fracIn)));
endmodule

// File: rtl/tslot_subst.sv
module tslot_subst
  import tslot_pkg::*;
#(
  parameter int T1_SLOTS = 24,
  parameter int E1_SLOTS = 32,
  parameter int PRBS_W   = 15,
  localparam int SLOT_W  = $clog2(E1_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              frameSync,
  input  logic              modeE1,
  input  logic              serIn,
  input  logic              fracIn,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgAddr,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic [7:0]        userCode,
  output logic              serOut
);
  ctrlStrobeT ctl;

  tslot_ctrl #(.T1_SLOTS(T1_SLOTS), .E1_SLOTS(E1_SLOTS)) i_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameSync(frameSync),
    .modeE1(modeE1), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgMode(cfgMode),
    .ctl(ctl)
  );

  tslot_dp #(.PRBS_W(PRBS_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .serIn(serIn), .fracIn(fracIn),
    .userCode(userCode), .serOut(serOut)
  );
endmodule

// File: tb/test_tslot_subst.sv
module test_tslot_subst;
  logic clk = 1'b0, rstN = 1'b0, bitEn = 1'b0, frameSync = 1'b0, modeE1 = 1'b0;
  logic serIn = 1'b0, fracIn = 1'b0, cfgWe = 1'b0, serOut;
  logic [4:0] cfgAddr = '0;
  logic [3:0] cfgMode = '0;
  logic [7:0] userCode = 8'hA6;

  always #5 clk = ~clk;

  tslot_subst i_tslot_subst (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameSync(frameSync), .modeE1(modeE1),
    .serIn(serIn), .fracIn(fracIn), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgMode(cfgMode), .userCode(userCode), .serOut(serOut)
  );

  int checks = 0, errors = 0;
  logic expQ[$];
  string tagQ[$];
  logic lastExp = 1'b0;
  string lastTag = "R1";
  logic seenEn = 1'b0;
  logic started = 1'b0;

  // reference model state
  logic [3:0] mShadow[32], mActive[32];
  logic mFbit = 1'b0;
  int mSlot = 0, mIdx = 0;
  logic [14:0] mLfsr = '1;
  string frameTag = "";

  always @(posedge clk) seenEn <= rstN && bitEn;

  always @(negedge clk) begin
    if (seenEn) begin
      if (expQ.size() == 0) begin
        errors++; $display("FAIL R2 output with no pending bit: actual %b expected none", serOut);
      end else begin
        lastExp = expQ.pop_front();
        lastTag = tagQ.pop_front();
        checks++;
        if (serOut !== lastExp) begin
          errors++;
          $display("FAIL %s bit mismatch: actual %b expected %b", lastTag, serOut, lastExp);
        end
      end
    end else if (started && rstN) begin
      checks++;
      if (serOut !== lastExp) begin
        errors++;
        $display("FAIL R2 hold between strobes: actual %b expected %b", serOut, lastExp);
      end
    end
  end

  function automatic string tagFor(int slot, logic [3:0] m);
    if (frameTag != "") return frameTag;
    if (modeE1 && (slot == 0 || slot == 16)) return "R11";
    if (mActive[slot] != mShadow[slot]) return "R10";
    case (m)
      4'd1, 4'd2, 4'd3, 4'd8, 4'd9: return "R5";
      4'd4, 4'd5, 4'd6, 4'd7:       return "R6";
      4'd10:                        return "R7";
      4'd11:                        return "R8";
      default:                      return "R9";
    endcase
  endfunction

  task automatic sendBit(input logic sync, input int idle);
    logic e;
    logic [3:0] m;
    logic [7:0] code;
    int b;
    string t;
    @(negedge clk);
    cfgWe = 1'b0;
    bitEn = 1'b1; frameSync = sync;
    serIn = 1'($urandom); fracIn = 1'($urandom);
    if (sync) begin
      for (int i = 0; i < 32; i++) mActive[i] = mShadow[i];
      mFbit = !modeE1; mSlot = 0; mIdx = 0;
    end
    if (mFbit) begin
      e = serIn; t = (frameTag != "") ? frameTag : "R4";
    end else begin
      m = mActive[mSlot];
      b = mIdx + 1; // bit number 1..8
      t = tagFor(mSlot, m);
      case (m)
        4'd1:  e = ~serIn;
        4'd2:  e = serIn ^ (b % 2 == 0);
        4'd3:  e = serIn ^ (b % 2 == 1);
        4'd8:  e = serIn ^ (b == 1);
        4'd9:  e = serIn ^ (b != 1);
        4'd10: begin e = mLfsr[14]; mLfsr = {mLfsr[13:0], mLfsr[14] ^ mLfsr[13]}; end
        4'd11: e = fracIn;
        4'd4, 4'd5, 4'd6, 4'd7: begin
          code = (m == 4'd4) ? userCode : (m == 4'd5) ? 8'hFF : (m == 4'd6) ? 8'hD5 : 8'h00;
          e = code[8 - b];
        end
        default: e = serIn;
      endcase
    end
    expQ.push_back(e); tagQ.push_back(t);
    if (mFbit) begin
      mFbit = 1'b0; mSlot = 0; mIdx = 0;
    end else if (mIdx == 7) begin
      mIdx = 0;
      if (mSlot == (modeE1 ? 31 : 23)) begin mSlot = 0; mFbit = !modeE1; end
      else mSlot++;
    end else mIdx++;
    started = 1'b1;
    for (int k = 0; k < idle; k++) begin
      @(negedge clk);
      bitEn = 1'b0; frameSync = 1'b0;
    end
  endtask

  task automatic writeCfg(input int a, input logic [3:0] m);
    @(negedge clk);
    bitEn = 1'b0; frameSync = 1'b0;
    cfgWe = 1'b1; cfgAddr = 5'(a); cfgMode = m;
    mShadow[a] = m;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic runBits(input int n, input logic firstSync, input int gap);
    for (int i = 0; i < n; i++)
      sendBit(firstSync && i == 0, (gap > 0) ? int'($urandom_range(gap)) : 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R2 watchdog expired: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin mShadow[i] = '0; mActive[i] = '0; end
    repeat (4) @(negedge clk);
    checks++;
    if (serOut !== 1'b0) begin
      errors++; $display("FAIL R1 reset output: actual %b expected 0", serOut);
    end
    rstN = 1'b1;
    // R1: default table passes everything; R4 framing bit included
    frameTag = "R1";
    runBits(193, 1'b1, 1);
    frameTag = "";
    // program T1 slots with every mode code (R5..R9)
    for (int i = 0; i < 24; i++) writeCfg(i, 4'(i % 16));
    runBits(193, 1'b1, 2);
    // R3: free-running second frame, no sync
    runBits(193, 1'b0, 0);
    // R10: shadow writes after sync must not affect current frame
    sendBit(1'b1, 0);
    writeCfg(5, 4'd5); writeCfg(20, 4'd11); writeCfg(1, 4'd0);
    userCode = 8'h3C;
    runBits(192, 1'b0, 1);
    runBits(193, 1'b1, 0);
    // E1: R11 slots 0 and 16 substituted
    modeE1 = 1'b1;
    for (int i = 0; i < 32; i++) writeCfg(i, 4'(i % 12));
    writeCfg(0, 4'd4); writeCfg(16, 4'd10);
    runBits(256, 1'b1, 1);
    frameTag = "R3";
    runBits(256, 1'b0, 0);
    frameTag = "";
    writeCfg(0, 4'd6); writeCfg(16, 4'd1); writeCfg(31, 4'd10);
    runBits(256, 1'b1, 2);
    // back to T1
    modeE1 = 1'b0;
    runBits(386, 1'b1, 1);
    @(negedge clk);
    bitEn = 1'b0; frameSync = 1'b0;
    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      errors++; $display("FAIL R2 results missing: actual %0d pending expected 0", expQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule